// File: doc/BRIEF.md
# PWM Pulse Generator with Output Clamping

This block drives one pulse-width-modulated output from a 16-bit down-counter. The counter advances once per count clock. The count clock is the base clock divided by 1, 4, 16 or 64. The counter restarts from a period value each time it underflows. While the count is above the duty value the output sits at its inactive level. Once the count reaches the duty value, the output takes its active level and holds it until the next underflow.

Software programs the block through a single-cycle write port. The period, duty and mask values go into shadow registers. They reach the running counter only at the underflow point, so a new waveform always starts on a clean cycle boundary. Two sticky event flags each have their own enable and drive one interrupt line. The first flags the underflow and the second flags the duty match. The output can be pinned to a constant level in two ways: with the mask bit, or by choosing a duty value that is not below the period.

Top module: `pwm_clamp_gen`

## Requirements
- R1: Control bits [4:3] select the count clock: 0 counts every base clock, 1 every 4th, 2 every 16th, 3 every 64th. The prescaler phase starts at zero when the block is enabled.
- R2: After enabling, the counter holds the period value (address 0). It steps down by one per count clock and, on the count clock where it is 0, reloads, so one waveform cycle lasts period+1 count clocks.
- R3: With the polarity bit (control bit 1) at 0, the output is low while the count is above the duty value (address 1) and high while it is at or below it.
- R4: With the polarity bit at 1 the output level is inverted. The bit takes effect on the cycle after it is written.
- R5: When the active mask bit (control bit 2) is 1, the output holds the inactive level: low under normal polarity, high under inverted polarity.
- R6: When duty is greater than or equal to period, the output holds the active level for the whole cycle. This includes period = duty = 0, which gives a constant high under normal polarity.
- R7: Period, duty and mask writes made while running take effect only at the next underflow. The value written together with the enable bit is used from the first cycle.
- R8: The underflow flag is set on each underflow and stays set. A write to address 3 with bit 0 at 0 clears it, and a 1 in bit 0 leaves it set.
- R9: The duty-match flag is set on each count clock where the count equals the active duty value and stays set. A write to address 3 with bit 1 at 0 clears it.
- R10: The interrupt output is the OR of the underflow flag gated by control bit 5 and the match flag gated by control bit 6.
- R11: With the enable bit (control bit 0) at 0, the counter and prescaler stop, no flags are raised, and the output holds the inactive level for the current polarity.
- R12: After reset the block is disabled, and the output and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select: 0 period, 1 duty, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Pulse output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the write port is the only path that changes the interrupt enables or clears a flag. They also assume that the block restarts only from the disabled state, never by rewriting the enable bit while running. The stimulus stops the block with a control write before it loads new settings, and only then enables it. Every write is held for exactly one cycle, and flag clears are timed so that they never fall on the same edge as the event they clear.

// File: rtl/pwm_clamp_pkg.sv
// Shared register addresses and control bit positions for the PWM generator.
// Assumes a control word of at least 7 bits.
package pwm_clamp_pkg;
    typedef enum logic [1:0] {
        ADDR_PERIOD = 2'd0,
        ADDR_DUTY   = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_FLAGS  = 2'd3
    } reg_addr_e;

    localparam int CTL_RUN    = 0;
    localparam int CTL_INV    = 1;
    localparam int CTL_MASK   = 2;
    localparam int CTL_SEL_LO = 3;
    localparam int CTL_BIE    = 5;
    localparam int CTL_MIE    = 6;
    localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/pwm_prescaler.sv
// Free-running divider that emits a one-cycle count-clock tick.
// Select value s gives a tick every 2**(STEP*s) base clocks.
// Assumes the divider restarts from zero whenever run is low.
module pwm_prescaler #(
    parameter int SEL_W = 2,
    parameter int STEP  = 2,
    localparam int DIV_W = STEP * ((1 << SEL_W) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    // Build the low-bit mask whose all-ones state marks a tick.
    always_comb begin
        div_mask = '0;
        for (int k = 0; k < DIV_W; k++) begin
            if (k < STEP * int'(sel)) div_mask[k] = 1'b1;
        end
    end

    assign tick = run && ((div_cnt & div_mask) == div_mask);

    // Advance the divider while running; clear it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_down_counter.sv
// Down-counter with active period/duty/mask registers loaded from the
// shadows at start and at each underflow. Emits underflow and match pulses.
// Assumes tick is only high while the block runs.
module pwm_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tick,
    input  logic [W-1:0] period_sh,
    input  logic [W-1:0] duty_sh,
    input  logic         mask_sh,
    output logic [W-1:0] cnt,
    output logic [W-1:0] act_duty,
    output logic         act_mask,
    output logic         borrow,
    output logic         match
);
    assign borrow = tick && (cnt == '0);
    assign match  = tick && (cnt == act_duty);

    // Reload count and active settings at start or underflow, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_duty <= '0;
            act_mask <= 1'b0;
        end else if (start || borrow) begin
            cnt      <= period_sh;
            act_duty <= duty_sh;
            act_mask <= mask_sh;
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pwm_irq_flags.sv
// Sticky event flags with clear-by-writing-zero and per-flag enables.
// Assumes a set and a clear of the same flag on one edge resolves to set.
module pwm_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    input  logic [N-1:0] ie,
    output logic         irq
);
    logic [N-1:0] flag;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one flag: set on event, drop on a zero written to its bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                        flag[i] <= 1'b0;
            else if (set_evt[i])               flag[i] <= 1'b1;
            else if (clr_wr && !clr_data[i])   flag[i] <= 1'b0;
        end
    end

    assign irq = |(flag & ie);
endmodule

// File: rtl/pwm_clamp_gen.sv
// Top of the PWM generator: register write decode, shadow registers,
// prescaler, down-counter, flags and the output level stage.
// Assumes one register write per cycle and CNT_W >= 7.
module pwm_clamp_gen
    import pwm_clamp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             irq
);
    logic [CNT_W-1:0]     period_sh, duty_sh;
    logic                 run, inv, mask_sh, mask_nx;
    logic [SEL_W-1:0]     sel;
    logic [NUM_FLAGS-1:0] ie;
    logic                 ctrl_wr, start, tick, borrow, match;
    logic [CNT_W-1:0]     cnt, act_duty;
    logic                 act_mask;

    assign ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
    assign start   = ctrl_wr && wr_data[CTL_RUN] && !run;
    assign mask_nx = ctrl_wr ? wr_data[CTL_MASK] : mask_sh;

    // Capture register writes into the shadow and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_sh <= '0;
            duty_sh   <= '0;
            run       <= 1'b0;
            inv       <= 1'b0;
            mask_sh   <= 1'b0;
            sel       <= '0;
            ie        <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_PERIOD: period_sh <= wr_data;
                ADDR_DUTY:   duty_sh   <= wr_data;
                ADDR_CTRL: begin
                    run     <= wr_data[CTL_RUN];
                    inv     <= wr_data[CTL_INV];
                    mask_sh <= wr_data[CTL_MASK];
                    sel     <= wr_data[CTL_SEL_LO +: SEL_W];
                    ie      <= {wr_data[CTL_MIE], wr_data[CTL_BIE]};
                end
                default: ;
            endcase
        end
    end

    pwm_prescaler #(.SEL_W(SEL_W), .STEP(STEP)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
    );

    pwm_down_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .period_sh(period_sh), .duty_sh(duty_sh), .mask_sh(mask_nx),
        .cnt(cnt), .act_duty(act_duty), .act_mask(act_mask),
        .borrow(borrow), .match(match)
    );

    pwm_irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_evt({match, borrow}),
        .clr_wr(wr_en && (reg_addr_e'(wr_addr) == ADDR_FLAGS)),
        .clr_data(wr_data[NUM_FLAGS-1:0]), .ie(ie), .irq(irq)
    );

    // Output level: inactive when stopped or masked, else duty comparison.
    always_comb begin
        if (!run || act_mask) pwm_out = inv;
        else                  pwm_out = (cnt <= act_duty) ^ inv;
    end
endmodule

// File: rtl/pwm_clamp_chk.sv
// Property checker for the PWM generator, attached by bind.
module pwm_clamp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         run,
    input logic         inv,
    input logic         act_mask,
    input logic         tick,
    input logic         borrow,
    input logic [W-1:0] cnt,
    input logic [W-1:0] period_sh,
    input logic         pwm_out,
    input logic         irq
);
    // R11
    stopped_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pwm_out == inv);

    // R5
    mask_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_mask) |-> pwm_out == inv);

    // R2
    borrow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |=> cnt == $past(period_sh));

    // R1
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);
endmodule

bind pwm_clamp_gen pwm_clamp_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .run(run), .inv(inv),
    .act_mask(act_mask), .tick(tick), .borrow(borrow), .cnt(cnt),
    .period_sh(period_sh), .pwm_out(pwm_out), .irq(irq)
);

// File: tb/pwm_clamp_gen_tb.sv
`timescale 1ns/1ps
module pwm_clamp_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out, irq;
    int          n_chk = 0, n_fail = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_clamp_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] duty;
        logic [1:0]  sel;
        logic        inv;
        logic        mask;
        logic [15:0] win;
        logic [15:0] high;
    } vec_t;

    // Window = 4 waveform cycles; high = cycles the output is 1 in it.
    localparam vec_t VECS [12] = '{
        '{16'd3, 16'd1, 2'd0, 1'b0, 1'b0, 16'd16,  16'd8},    // R3
        '{16'd3, 16'd0, 2'd0, 1'b1, 1'b0, 16'd16,  16'd12},   // R4
        '{16'd3, 16'd1, 2'd0, 1'b0, 1'b1, 16'd16,  16'd0},    // R5
        '{16'd3, 16'd1, 2'd0, 1'b1, 1'b1, 16'd16,  16'd16},   // R5
        '{16'd5, 16'd5, 2'd0, 1'b0, 1'b0, 16'd24,  16'd24},   // R6
        '{16'd5, 16'd5, 2'd0, 1'b1, 1'b0, 16'd24,  16'd0},    // R6
        '{16'd0, 16'd0, 2'd0, 1'b0, 1'b0, 16'd4,   16'd4},    // R6
        '{16'd2, 16'd0, 2'd1, 1'b0, 1'b0, 16'd48,  16'd16},   // R1
        '{16'd4, 16'd2, 2'd2, 1'b0, 1'b0, 16'd320, 16'd192},  // R1
        '{16'd1, 16'd0, 2'd3, 1'b0, 1'b0, 16'd512, 16'd256},  // R1
        '{16'd4, 16'd7, 2'd0, 1'b0, 1'b0, 16'd20,  16'd20},   // R6
        '{16'd6, 16'd2, 2'd0, 1'b0, 1'b0, 16'd28,  16'd12}    // R2
    };

    localparam logic [15:0] RUN = 16'h0001, INV = 16'h0002, MSK = 16'h0004;
    localparam logic [15:0] BIE = 16'h0020, MIE = 16'h0040;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 out", pwm_out, 0);
        check("R12 irq", irq, 0);

        for (int v = 0; v < 12; v++) begin
            int hi;
            hi = 0;
            wr(2'd2, 16'h0000);
            wr(2'd0, VECS[v].per);
            wr(2'd1, VECS[v].duty);
            wr(2'd2, {9'b0, 2'b00, VECS[v].sel, VECS[v].mask, VECS[v].inv, 1'b1});
            for (int i = 0; i < int'(VECS[v].win); i++) begin
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check($sformatf("R1-R6 vector %0d high count", v), hi, int'(VECS[v].high));
        end

        // R8 underflow flag, sticky, clear by zero
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd1);
        wr(2'd3, 16'h0000);
        wr(2'd2, RUN | BIE);
        wait_n(3);
        check("R8 before underflow", irq, 0);
        wait_n(1);
        check("R8 after underflow", irq, 1);
        wait_n(10);
        check("R8 sticky", irq, 1);
        wr(2'd3, 16'h0002);
        check("R8 cleared", irq, 0);

        // R9 match flag; R10 enable gating
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0000);
        wr(2'd2, RUN | MIE);
        wait_n(2);
        check("R9 before match", irq, 0);
        wait_n(1);
        check("R9 after match", irq, 1);
        wr(2'd3, 16'h0001);
        check("R9 cleared, R10 underflow gated off", irq, 0);
        wr(2'd2, RUN | MIE | BIE);
        check("R10 underflow enabled", irq, 1);

        // R7 duty shadow applies at underflow only
        wr(2'd2, 16'h0000);
        wr(2'd2, RUN);
        wr(2'd1, 16'd3);
        check("R7 old duty kept", pwm_out, 0);
        wait_n(3);
        check("R7 new duty after reload", pwm_out, 1);

        // R7 mask takes effect at underflow (no cut pulse)
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'd1);
        wr(2'd2, RUN);
        wr(2'd2, RUN | MSK);
        wait_n(1);
        check("R7 mask pending", pwm_out, 1);
        wait_n(2);
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 8; i++) begin
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check("R5 masked after reload", hi, 0);
        end

        // R11 stopped level and no events
        wr(2'd2, 16'h0000);
        check("R11 stopped normal", pwm_out, 0);
        wr(2'd2, INV | BIE);
        check("R11 stopped inverted", pwm_out, 1);
        wr(2'd3, 16'h0000);
        wait_n(20);
        check("R11 no underflow while stopped", irq, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule